// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block is an interval timer built from two registers of equal width. A free-running Count register advances by one on every cycle in which the tick-enable input is high, and wraps to zero after its largest value. A Compare register holds a target value and changes only when software writes it. When the two registers hold equal values, the block raises a timer interrupt one clock later. The interrupt is sticky: it stays high after Count moves past the target, and the only way to drop it is to write Compare. That write clears the interrupt whatever value is written.

Software reaches both registers through a small register port. The port has a one-bit select, a write enable, write data, and read data that is decoded combinationally from the select. The timer interrupt is available on its own output. It is also ORed with an external hardware interrupt input, so that both sources can feed one interrupt-pending bit of a cause vector (bit 7 in a typical arrangement).

Top module: `timer_cmp_unit`

## Requirements
- R1: When the port is not writing Count, Count rises by exactly one on each clock edge at which `tick_en_i` is high, and holds its value when `tick_en_i` is low. When `tick_en_i` is pulsed only every few cycles, Count advances once per pulse.
- R2: Count wraps from its all-ones value to zero on a tick.
- R3: A write with `reg_sel_i` = 0 (Count) loads `wr_data_i` into Count at the clock edge. This takes priority over a tick in the same cycle.
- R4: A write with `reg_sel_i` = 1 (Compare) loads Compare. Compare never changes otherwise. `rd_data_o` shows Count when `reg_sel_i` = 0 and Compare when it is 1, in the same cycle.
- R5: `timer_irq_o` rises at the clock edge that follows a cycle in which Count equals Compare, and at no other time.
- R6: Once set, `timer_irq_o` stays high while Count keeps moving, until Compare is written.
- R7: Any Compare write clears `timer_irq_o` at its clock edge, even when the written value equals the current one or equality holds in that same cycle. Matching then resumes against the new value.
- R8: A write to Count leaves a pending `timer_irq_o` unchanged.
- R9: `irq_line7_o` is high whenever `timer_irq_o` or `hw5_irq_i` is high, and low otherwise.
- R10: Synchronous reset puts Count at zero and `timer_irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en_i | input | 1 | Count advance enable |
| reg_sel_i | input | 1 | Register select: 0 = Count, 1 = Compare |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | CNT_W | Write data |
| rd_data_o | output | CNT_W | Selected register value |
| hw5_irq_i | input | 1 | External hardware interrupt shared with the timer |
| timer_irq_o | output | 1 | Sticky timer interrupt |
| irq_line7_o | output | 1 | Timer interrupt ORed with `hw5_irq_i` |

## Verification
The bench builds the unit with `CNT_W` = 12. At that width a full trip of Count around its range takes only 4096 ticks. This makes two things practical to observe: a natural rollover, and the exact number of edges between clearing the interrupt just past the target and its next rise one lap later. Writes of values next to the all-ones value exercise the wrap boundary directly. Collisions between a Compare write and a live match are timed to the exact edge.

// File: rtl/timer_cmp_pkg.sv
package timer_cmp_pkg;

    typedef enum logic {
        SEL_COUNT   = 1'b0,
        SEL_COMPARE = 1'b1
    } tmr_sel_e;

    typedef struct packed {
        logic load_count;
        logic load_compare;
    } tmr_wr_t;

    function automatic tmr_wr_t decode_write(input logic wr_en, input tmr_sel_e sel);
        tmr_wr_t w;
        w.load_count   = wr_en && (sel == SEL_COUNT);
        w.load_compare = wr_en && (sel == SEL_COMPARE);
        return w;
    endfunction

endpackage

// File: rtl/tmr_count_reg.sv
module tmr_count_reg #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    logic [CNT_W-1:0] count_q;

    // Software load wins over the tick; wrap is natural modulo arithmetic.
    always_ff @(posedge clk) begin
        if (rst)          count_q <= '0;
        else if (load)    count_q <= load_val;
        else if (tick_en) count_q <= count_q + STEP;
    end

    assign count = count_q;
endmodule

// File: rtl/tmr_compare_reg.sv
module tmr_compare_reg #(
    parameter int               CNT_W   = 32,
    parameter logic [CNT_W-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] target
);
    logic [CNT_W-1:0] target_q;

    always_ff @(posedge clk) begin
        if (rst)       target_q <= RST_VAL;
        else if (load) target_q <= load_val;
    end

    assign target = target_q;
endmodule

// File: rtl/tmr_irq_latch.sv
module tmr_irq_latch #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] target,
    input  logic             clear,
    output logic             irq
);
    logic hit;
    logic irq_q;

    assign hit = (count == target);

    // Clear has priority over a same-cycle hit; set is registered.
    always_ff @(posedge clk) begin
        if (rst)        irq_q <= 1'b0;
        else if (clear) irq_q <= 1'b0;
        else if (hit)   irq_q <= 1'b1;
    end

    assign irq = irq_q;
endmodule

// File: rtl/timer_cmp_unit.sv
module timer_cmp_unit
    import timer_cmp_pkg::*;
#(
    parameter int               CNT_W       = 32,
    parameter logic [CNT_W-1:0] CMP_RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en_i,
    input  logic             reg_sel_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] rd_data_o,
    input  logic             hw5_irq_i,
    output logic             timer_irq_o,
    output logic             irq_line7_o
);
    tmr_sel_e         sel;
    tmr_wr_t          wreq;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] cmp_q;
    logic             irq_q;

    assign sel  = tmr_sel_e'(reg_sel_i);
    assign wreq = decode_write(wr_en_i, sel);

    tmr_count_reg #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en_i),
        .load     (wreq.load_count),
        .load_val (wr_data_i),
        .count    (count_q)
    );

    tmr_compare_reg #(.CNT_W(CNT_W), .RST_VAL(CMP_RST_VAL)) u_compare (
        .clk      (clk),
        .rst      (rst),
        .load     (wreq.load_compare),
        .load_val (wr_data_i),
        .target   (cmp_q)
    );

    tmr_irq_latch #(.CNT_W(CNT_W)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .count  (count_q),
        .target (cmp_q),
        .clear  (wreq.load_compare),
        .irq    (irq_q)
    );

    always_comb begin
        unique case (sel)
            SEL_COUNT:   rd_data_o = count_q;
            SEL_COMPARE: rd_data_o = cmp_q;
            default:     rd_data_o = count_q;
        endcase
    end

    assign timer_irq_o = irq_q;
    assign irq_line7_o = irq_q | hw5_irq_i;
endmodule

// File: rtl/timer_cmp_unit_chk.sv
module timer_cmp_unit_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en_i,
    input logic             reg_sel_i,
    input logic             wr_en_i,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] cmp_q,
    input logic             timer_irq_o
);
    logic cnt_wr;
    logic cmp_wr;
    assign cnt_wr = wr_en_i && !reg_sel_i;
    assign cmp_wr = wr_en_i &&  reg_sel_i;

    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        (!cnt_wr && tick_en_i) |=> count_q == CNT_W'($past(count_q) + CNT_W'(1)));

    p_count_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!cnt_wr && !tick_en_i) |=> $stable(count_q));

    p_cmp_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !cmp_wr |=> $stable(cmp_q));

    p_irq_rise_r5: assert property (@(posedge clk) disable iff (rst)
        (count_q == cmp_q && !cmp_wr) |=> timer_irq_o);

    p_irq_origin_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(timer_irq_o) |-> $past(count_q == cmp_q));

    p_irq_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (timer_irq_o && !cmp_wr) |=> timer_irq_o);

    p_irq_clear_r7: assert property (@(posedge clk) disable iff (rst)
        cmp_wr |=> !timer_irq_o);

    p_reset_r10: assert property (@(posedge clk)
        rst |=> (count_q == '0 && !timer_irq_o));
endmodule

bind timer_cmp_unit timer_cmp_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_en_i   (tick_en_i),
    .reg_sel_i   (reg_sel_i),
    .wr_en_i     (wr_en_i),
    .count_q     (count_q),
    .cmp_q       (cmp_q),
    .timer_irq_o (timer_irq_o)
);

// File: tb/timer_cmp_unit_tb.sv
module timer_cmp_unit_tb;
    localparam int W = 12;
    localparam logic [W-1:0] MAXV = '1;

    logic         clk = 1'b0;
    logic         rst;
    logic         tick_en;
    logic         sel;
    logic         wr_en;
    logic [W-1:0] wdata;
    logic [W-1:0] rdata;
    logic         hw5;
    logic         tirq;
    logic         line7;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    timer_cmp_unit #(.CNT_W(W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .tick_en_i   (tick_en),
        .reg_sel_i   (sel),
        .wr_en_i     (wr_en),
        .wr_data_i   (wdata),
        .rd_data_o   (rdata),
        .hw5_irq_i   (hw5),
        .timer_irq_o (tirq),
        .irq_line7_o (line7)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive at a falling edge; the write lands at the following rising edge.
    task automatic reg_write(input logic s, input logic [W-1:0] v);
        @(negedge clk);
        sel = s; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_count(output int v);
        sel = 1'b0; #1 v = int'(rdata);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        int v;
        read_count(v);
        check("R10 count after reset", v, 0);
        check("R10 irq after reset", int'(tirq), 0);
    endtask

    task automatic t_ticks;
        int v;
        tick_en = 1'b0;
        reg_write(1'b0, 12'd10);
        idle(3);
        read_count(v);
        check("R1 hold without tick", v, 10);
        for (int i = 0; i < 4; i++) begin
            tick_en = 1'b1; @(negedge clk);
            tick_en = 1'b0; idle(2);
        end
        read_count(v);
        check("R1 divided tick rate", v, 14);
        tick_en = 1'b1; idle(5); tick_en = 1'b0;
        read_count(v);
        check("R1 continuous ticks", v, 19);
    endtask

    task automatic t_wrap;
        int v;
        reg_write(1'b0, MAXV - 12'd1);
        tick_en = 1'b1; idle(1);
        read_count(v);
        check("R2 reaches all-ones", v, int'(MAXV));
        idle(1); tick_en = 1'b0;
        read_count(v);
        check("R2 wrap to zero", v, 0);
    endtask

    task automatic t_count_write_priority;
        int v;
        tick_en = 1'b1;
        reg_write(1'b0, 12'd500);
        tick_en = 1'b0;
        read_count(v);
        check("R3 write beats tick", v, 500);
    endtask

    task automatic t_compare_rw;
        int v;
        reg_write(1'b1, 12'd1234);
        tick_en = 1'b1; idle(4); tick_en = 1'b0;
        sel = 1'b1; #1 v = int'(rdata);
        check("R4 compare readback and stable", v, 1234);
    endtask

    task automatic t_irq_timing;
        int v;
        tick_en = 1'b0;
        reg_write(1'b1, 12'd50);
        reg_write(1'b0, 12'd49);
        check("R5 no irq before match", int'(tirq), 0);
        tick_en = 1'b1;
        @(negedge clk);
        read_count(v);
        check("R5 count at target", v, 50);
        check("R5 irq not yet during match cycle", int'(tirq), 0);
        @(negedge clk);
        check("R5 irq one edge after match", int'(tirq), 1);
        idle(20);
        check("R6 irq sticky after count moves", int'(tirq), 1);
        tick_en = 1'b0;
    endtask

    task automatic t_count_write_keeps;
        reg_write(1'b0, 12'd5);
        idle(3);
        check("R8 count write keeps irq", int'(tirq), 1);
    endtask

    task automatic t_clear;
        reg_write(1'b1, 12'd3000);
        check("R7 compare write clears", int'(tirq), 0);
        idle(5);
        check("R7 stays clear without match", int'(tirq), 0);
        // Count 5 held; write Compare 5 then rewrite same value during live match.
        reg_write(1'b1, 12'd5);
        check("R7 cleared at write edge", int'(tirq), 0);
        @(negedge clk);
        check("R5 match against new compare", int'(tirq), 1);
        sel = 1'b1; wdata = 12'd5; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        check("R7 write beats same-cycle match", int'(tirq), 0);
        @(negedge clk);
        check("R7 rematch after collision", int'(tirq), 1);
    endtask

    task automatic t_hw5;
        reg_write(1'b1, 12'd4000);
        hw5 = 1'b0; #1;
        check("R9 both low", int'(line7), 0);
        hw5 = 1'b1; #1;
        check("R9 hw5 alone", int'(line7), 1);
        check("R9 hw5 does not set timer", int'(tirq), 0);
        hw5 = 1'b0;
        reg_write(1'b1, 12'd5);
        @(negedge clk); #1;
        check("R9 timer alone", int'(line7), 1);
    endtask

    task automatic t_full_lap;
        int edges;
        tick_en = 1'b0;
        reg_write(1'b0, 12'd101);
        reg_write(1'b1, 12'd100);
        check("R7 cleared before lap", int'(tirq), 0);
        tick_en = 1'b1;
        edges = 0;
        while (!tirq && edges < 5000) begin
            @(negedge clk);
            edges++;
        end
        tick_en = 1'b0;
        check("R2 lap length to irq", edges, 4096);
    endtask

    initial begin
        rst = 1'b1; tick_en = 1'b0; sel = 1'b0; wr_en = 1'b0; wdata = '0; hw5 = 1'b0;
        idle(3);
        rst = 1'b0;
        t_reset();
        t_ticks();
        t_wrap();
        t_count_write_priority();
        t_compare_rw();
        t_irq_timing();
        t_count_write_keeps();
        t_clear();
        t_hw5();
        t_full_lap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule